// File: doc/BRIEF.md
# Word-Addressed Interrupt Controller

This block gathers up to 32 interrupt request lines into one interrupt output for a processor. Each request is latched into a status register and masked by an enable register. The processor reaches the controller through a simple register bus with eight word addresses. A write completes on a single clock edge, and a read returns data combinationally from the current address.

Each source is fixed at build time as edge-captured or level-sensed. An edge source latches on a rising transition of its input. A level source re-latches on every cycle its input is high. As a result, a level source can only be cleared for good once its input has dropped.

Enable bits can be changed without a read-modify-write sequence, through a set-alias register and a clear-alias register. A vector register returns the number of the lowest pending source. A two-bit master register does two jobs: one bit gates the output line, and the other gates hardware capture.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, the status, enable and master registers read zero, the vector reads 0xFFFFFFFF, and `irq_out` is low.
- R2: The word offsets are fixed as follows: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master. Writes to offsets 1 and 6 change nothing. Offsets 3, 4 and 5 read zero.
- R3: Writing a mask to offset 4 sets those enable bits on the next edge and leaves all other enable bits unchanged.
- R4: Writing a mask to offset 5 clears those enable bits on the next edge and leaves all other enable bits unchanged.
- R5: A write to offset 2 replaces the whole enable register, so writing zero disables every source.
- R6: Writing ones to offset 3 clears the matching status bits. A level source whose input is still high is set again in the same cycle, so for that source the acknowledge has no lasting effect.
- R7: A source whose bit in the build-time kind mask is 1 (an edge source) sets its status bit only on a cycle where its input is high and was low on the previous edge.
- R8: A source whose kind bit is 0 (a level source) sets its status bit on every edge at which its input is high.
- R9: Master bit 1 enables hardware capture. While it is 0, status changes only through writes to offset 0 (which replace it) or offset 3.
- R10: Offset 1 reads status AND enable.
- R11: Offset 6 reads the index of the lowest-numbered pending source, or 0xFFFFFFFF when nothing is pending.
- R12: `irq_out` is high exactly when master bit 0 is 1 and at least one pending bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 3 | Word offset of the register accessed |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_src | input | N_SRC | Interrupt request inputs |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
A corrupted status or enable bit appears at the pending and vector offsets, and possibly at `irq_out`, in the cycle right after the edge that stored it. The bench therefore compares all eight offsets and the output line against a behavioural model after every edge. A lost or doubled edge capture shows as a status mismatch one cycle after the input transition. A wrong alias mask shows at offset 2 one cycle after the write.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    OFS_STATUS  = 3'd0,
    OFS_PENDING = 3'd1,
    OFS_ENABLE  = 3'd2,
    OFS_ACK     = 3'd3,
    OFS_EN_SET  = 3'd4,
    OFS_EN_CLR  = 3'd5,
    OFS_VECTOR  = 3'd6,
    OFS_MASTER  = 3'd7
  } reg_ofs_e;

  localparam logic [BUS_W-1:0] NO_VECTOR = '1;
endpackage

// File: rtl/irqc_capture.sv
`timescale 1ns/1ps
module irqc_capture #(
  parameter int unsigned   N_SRC     = 32,
  parameter logic [N_SRC-1:0] EDGE_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [N_SRC-1:0] src,
  output logic [N_SRC-1:0] hw_set
);
  logic [N_SRC-1:0] src_q, src_d;
  logic [N_SRC-1:0] events;

  always_comb begin
    src_d = src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_d;
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_kind
    if (EDGE_MASK[g]) begin : g_edge
      assign events[g] = src[g] & ~src_q[g];
    end else begin : g_level
      assign events[g] = src[g];
    end
  end

  assign hw_set = events & {N_SRC{cap_en}};

  // R9: capture gated off by master bit 1
  property p_gate;
    @(posedge clk) disable iff (!rst_n) !cap_en |-> (hw_set == '0);
  endproperty
  a_r9_capture_gated: assert property (p_gate);
endmodule

// File: rtl/irqc_regfile.sv
`timescale 1ns/1ps
module irqc_regfile
  import irqc_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [BUS_W-1:0]      wr_data,
  input  logic [N_SRC-1:0]      hw_set,
  output logic [N_SRC-1:0]      status,
  output logic [N_SRC-1:0]      enable,
  output logic [1:0]            master
);
  logic [N_SRC-1:0] wmask;
  logic [N_SRC-1:0] status_d, enable_d;
  logic [1:0]       master_d;
  logic             wr_stat, wr_ack, wr_en_all, wr_set, wr_clr, wr_mst;
  logic             status_ce, enable_ce, master_ce;

  assign wmask     = wr_data[N_SRC-1:0];
  assign wr_stat   = wr_en && (wr_addr == OFS_STATUS);
  assign wr_ack    = wr_en && (wr_addr == OFS_ACK);
  assign wr_en_all = wr_en && (wr_addr == OFS_ENABLE);
  assign wr_set    = wr_en && (wr_addr == OFS_EN_SET);
  assign wr_clr    = wr_en && (wr_addr == OFS_EN_CLR);
  assign wr_mst    = wr_en && (wr_addr == OFS_MASTER);

  always_comb begin
    status_d = status;
    if (wr_stat)     status_d = wmask;
    else if (wr_ack) status_d = status & ~wmask;
    status_d  = status_d | hw_set;
    status_ce = wr_stat | wr_ack | (|hw_set);

    enable_d = enable;
    if (wr_en_all)   enable_d = wmask;
    else if (wr_set) enable_d = enable | wmask;
    else if (wr_clr) enable_d = enable & ~wmask;
    enable_ce = wr_en_all | wr_set | wr_clr;

    master_d  = wr_data[1:0];
    master_ce = wr_mst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status <= '0;
    else if (status_ce) status <= status_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         enable <= '0;
    else if (enable_ce) enable <= enable_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         master <= '0;
    else if (master_ce) master <= master_d;
  end

  property p_set;
    @(posedge clk) disable iff (!rst_n)
      wr_set |=> ((enable & $past(wmask)) == $past(wmask));
  endproperty
  a_r3_set_alias: assert property (p_set);

  property p_set_keep;
    @(posedge clk) disable iff (!rst_n)
      wr_set |=> ((enable & ~$past(wmask)) == ($past(enable) & ~$past(wmask)));
  endproperty
  a_r3_set_keeps_others: assert property (p_set_keep);

  property p_clr;
    @(posedge clk) disable iff (!rst_n)
      wr_clr |=> ((enable & $past(wmask)) == '0);
  endproperty
  a_r4_clear_alias: assert property (p_clr);

  property p_ack;
    @(posedge clk) disable iff (!rst_n)
      (wr_ack && !master[1]) |=> ((status & $past(wmask)) == '0);
  endproperty
  a_r6_ack_clears: assert property (p_ack);

  property p_hold;
    @(posedge clk) disable iff (!rst_n)
      (!wr_en && !master[1]) |=> $stable(status);
  endproperty
  a_r9_status_hold: assert property (p_hold);
endmodule

// File: rtl/irqc_prio_enc.sv
`timescale 1ns/1ps
module irqc_prio_enc #(
  parameter int unsigned N_SRC = 32,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] pend,
  output logic [IDX_W-1:0] idx,
  output logic             valid
);
  always_comb begin
    idx   = '0;
    valid = 1'b0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        idx   = IDX_W'(i);
        valid = 1'b1;
      end
    end
  end

  // R11: reported source is pending and no lower one is
  property p_lowest;
    @(posedge clk) disable iff (!rst_n)
      valid |-> (pend[idx] &&
                 ((pend & ((N_SRC'(1) << idx) - N_SRC'(1))) == '0));
  endproperty
  a_r11_lowest_pending: assert property (p_lowest);

  property p_none;
    @(posedge clk) disable iff (!rst_n) !valid |-> (pend == '0);
  endproperty
  a_r11_none_pending: assert property (p_none);
endmodule

// File: rtl/irq_ctrl.sv
`timescale 1ns/1ps
module irq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned      N_SRC     = 32,
  parameter logic [N_SRC-1:0] EDGE_MASK = 32'hFFFF_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [N_SRC-1:0] irq_src,
  output logic             irq_out
);
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [1:0]       rst_sync;
  logic             core_rst_n;
  logic [N_SRC-1:0] hw_set, status, enable, pending;
  logic [1:0]       master;
  logic [IDX_W-1:0] vec_idx;
  logic             vec_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  irqc_capture #(.N_SRC(N_SRC), .EDGE_MASK(EDGE_MASK)) u_capture (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .cap_en (master[1]),
    .src    (irq_src),
    .hw_set (hw_set)
  );

  irqc_regfile #(.N_SRC(N_SRC)) u_regs (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .wr_en   (bus_wr),
    .wr_addr (bus_addr),
    .wr_data (bus_wdata),
    .hw_set  (hw_set),
    .status  (status),
    .enable  (enable),
    .master  (master)
  );

  assign pending = status & enable;

  irqc_prio_enc #(.N_SRC(N_SRC)) u_prio (
    .clk   (clk),
    .rst_n (core_rst_n),
    .pend  (pending),
    .idx   (vec_idx),
    .valid (vec_valid)
  );

  assign irq_out = master[0] & vec_valid;

  always_comb begin
    bus_rdata = '0;
    unique case (reg_ofs_e'(bus_addr))
      OFS_STATUS:  bus_rdata[N_SRC-1:0] = status;
      OFS_PENDING: bus_rdata[N_SRC-1:0] = pending;
      OFS_ENABLE:  bus_rdata[N_SRC-1:0] = enable;
      OFS_VECTOR:  begin
        if (vec_valid) bus_rdata[IDX_W-1:0] = vec_idx;
        else           bus_rdata = NO_VECTOR;
      end
      OFS_MASTER:  bus_rdata[1:0] = master;
      default:     bus_rdata = '0;
    endcase
  end

  // R12: line silent when master bit 0 is clear
  property p_irq_off;
    @(posedge clk) disable iff (!core_rst_n) !master[0] |-> !irq_out;
  endproperty
  a_r12_master_gates: assert property (p_irq_off);

  property p_irq_vec;
    @(posedge clk) disable iff (!core_rst_n) irq_out |-> (bus_addr != OFS_VECTOR || bus_rdata != NO_VECTOR);
  endproperty
  a_r12_irq_has_vector: assert property (p_irq_vec);
endmodule

// File: tb/irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl_tb_top;
  localparam logic [31:0] KIND = 32'hFFFF_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_src = '0;
  logic        irq_out;

  int n_tests = 0;
  int n_fail  = 0;

  irq_ctrl #(.N_SRC(32), .EDGE_MASK(KIND)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_src(irq_src), .irq_out(irq_out)
  );

  always #4 clk = ~clk;

  // behavioural reference state
  logic [31:0] m_stat, m_en, m_prev;
  logic [1:0]  m_mst;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat = 0; m_en = 0; m_prev = 0; m_mst = 0;
    end else begin
      logic [31:0] s;
      s = m_stat;
      if (bus_wr) begin
        case (bus_addr)
          3'd0: s = bus_wdata;
          3'd3: s = m_stat & ~bus_wdata;
          3'd2: m_en = bus_wdata;
          3'd4: m_en = m_en | bus_wdata;
          3'd5: m_en = m_en & ~bus_wdata;
          3'd7: m_mst = bus_wdata[1:0];
          default: ;
        endcase
      end
      if (m_mst_old_cap()) begin
        for (int i = 0; i < 32; i++) begin
          if (KIND[i] ? (irq_src[i] && !m_prev[i]) : irq_src[i]) s[i] = 1'b1;
        end
      end
      m_stat = s;
      m_prev = irq_src;
      m_cap  = m_mst[1];
    end
  end

  // capture enable as it stood before this edge's master write
  logic m_cap = 1'b0;
  function automatic logic m_mst_old_cap();
    return m_cap;
  endfunction
  always @(negedge rst_n) m_cap = 1'b0;

  function automatic logic [31:0] exp_read(input int a);
    logic [31:0] p;
    p = m_stat & m_en;
    case (a)
      0: return m_stat;
      1: return p;
      2: return m_en;
      6: begin
        for (int i = 0; i < 32; i++) if (p[i]) return i;
        return 32'hFFFF_FFFF;
      end
      7: return {30'd0, m_mst};
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input int a);
    case (a)
      0: return "R6 status";
      1: return "R10 pending";
      2: return "R3 enable";
      6: return "R11 vector";
      7: return "R9 master";
      default: return "R2 write-only offset";
    endcase
  endfunction

  task automatic peek(input int a, output logic [31:0] v);
    bus_addr = 3'(a);
    #0.2;
    v = bus_rdata;
  endtask

  // advance one edge, then compare every offset and the line
  task automatic tick();
    logic [31:0] v;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    for (int a = 0; a < 8; a++) begin
      peek(a, v);
      check(tag_of(a), v, exp_read(a));
    end
    check("R12 irq_out", {31'd0, irq_out},
          {31'd0, m_mst[0] && ((m_stat & m_en) != 0)});
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_addr = 3'(a); bus_wdata = d; bus_wr = 1'b1;
    tick();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  initial begin
    #150000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] lf;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    peek(0, v); check("R1 status", v, 0);
    peek(2, v); check("R1 enable", v, 0);
    peek(7, v); check("R1 master", v, 0);
    peek(6, v); check("R1 vector", v, 32'hFFFF_FFFF);
    check("R1 irq_out", {31'd0, irq_out}, 0);
    idle(1);

    // bring-up sequence
    wr(2, 0);
    wr(3, 32'hFFFF_FFFF);
    wr(7, 3);
    // R3 / R4 aliases
    wr(4, 32'h0001_0003);
    peek(2, v); check("R3 set alias", v, 32'h0001_0003);
    wr(5, 32'h0000_0002);
    peek(2, v); check("R4 clear alias", v, 32'h0001_0001);

    // R8 level source 0
    irq_src[0] = 1'b1; idle(3);
    peek(0, v); check("R8 level latched", v & 1, 1);
    wr(3, 1);
    peek(0, v); check("R6 ack while level high", v & 1, 1);
    irq_src[0] = 1'b0; idle(1);
    wr(3, 1);
    peek(0, v); check("R6 ack after drop", v & 1, 0);

    // R7 edge source 16
    irq_src[16] = 1'b1; idle(2);
    peek(0, v); check("R7 edge latched", v, 32'h0001_0000);
    wr(3, 32'h0001_0000);
    idle(3);
    peek(0, v); check("R7 held input no relatch", v, 0);
    irq_src[16] = 1'b0; idle(1);
    irq_src[16] = 1'b1; idle(1);
    peek(0, v); check("R7 second edge", v, 32'h0001_0000);
    irq_src[16] = 1'b0;
    wr(3, 32'hFFFF_FFFF);

    // R9 capture off, direct status write
    wr(7, 1);
    irq_src[4] = 1'b1; irq_src[20] = 1'b1; idle(2);
    peek(0, v); check("R9 no capture", v, 0);
    wr(0, 32'h0000_0028);
    wr(4, 32'h0000_0028);
    peek(6, v); check("R11 lowest of 3,5", v, 3);
    wr(5, 32'h0000_0008);
    peek(6, v); check("R11 next lowest", v, 5);
    irq_src[4] = 1'b0; irq_src[20] = 1'b0;
    wr(7, 0);
    check("R12 master off", {31'd0, irq_out}, 0);
    // R2 writes to pending/vector ignored
    wr(1, 32'hFFFF_FFFF);
    wr(6, 32'h0);
    peek(0, v); check("R2 status untouched", v, 32'h0000_0028);
    // R5 enable zero
    wr(2, 0);
    peek(1, v); check("R5 all disabled", v, 0);

    // pseudo-random traffic, model compared every cycle
    lf = 32'hACE1_2345;
    for (int k = 0; k < 600; k++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      irq_src = irq_src ^ (lf & {lf[7:0], lf[31:8]});
      bus_addr = lf[10:8];
      bus_wdata = (lf[13:12] == 0) ? 32'hFFFF_FFFF : {lf[5:0], lf[31:6]};
      bus_wr = lf[16] | lf[17];
      if (bus_addr == 3'd7 && lf[20]) bus_wdata = 3;
      tick();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule